// File: doc/BRIEF.md
# PLCP Path Status Alarm Monitor

This block watches the path status byte carried once per received PLCP frame. It does two jobs with that byte. First, it filters the remote alarm flag through a hysteresis state machine, so the alarm state changes only after an unbroken run of frames that all disagree with it. Second, it adds the remote error value carried in the upper nibble of the byte to a saturating error counter.

The framer that feeds the block pulses `stat_vld` when the status byte of a frame is on `stat_byte`. It pulses `frame_sof` at the frame boundary that follows. The boundary commits the captured byte to both the alarm filter and the error counter. A host reads the error count by pulsing `rd_req`. That pulse moves the live count into a holding register and restarts the live count in the same cycle.

Top module: `plcp_status_mon`

## Requirements
- R1: After reset, `alarm` is 0, `alarm_chg` is 0, `err_hold` is 0 and the live error count is 0.
- R2: The alarm flag is `stat_byte[3]`, which is the fifth bit when counting from the MSB as bit 1. While `alarm` is 0, it becomes 1 at the tenth consecutive committed frame whose flag is 1.
- R3: While `alarm` is 1, it returns to 0 at the tenth consecutive committed frame whose flag is 0.
- R4: A committed frame whose flag equals the current `alarm` value restarts the run, so only an unbroken run of ten disagreeing frames changes the state.
- R5: `alarm_chg` is high for exactly one cycle, in the same cycle that the new `alarm` value first appears. It is low at all other times.
- R6: The remote error field is `stat_byte[7:4]`. A committed frame whose field value v is in the range 0 to 8 adds v to the live error count.
- R7: A committed frame whose field value is 9h to Fh adds 0 to the count.
- R8: The live error count is 16 bits wide. It stops at FFFFh and does not wrap.
- R9: When `rd_req` is high, the live count is copied to `err_hold` and the live count is cleared, both in that cycle. An increment that is committed in the same cycle becomes the new live count.
- R10: A frame is committed only when `frame_sof` is high after a status byte has been captured since the last commit. A `frame_sof` with no new byte has no effect on the alarm run or the count. A captured byte affects neither until its `frame_sof` arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_byte | input | 8 | Path status byte; bits [7:4] hold the error value, bit 3 is the alarm flag |
| stat_vld | input | 1 | Captures `stat_byte` for the current frame |
| frame_sof | input | 1 | Frame boundary; commits the captured byte |
| rd_req | input | 1 | Copies the live count to `err_hold` and clears the live count |
| alarm | output | 1 | Filtered remote alarm state |
| alarm_chg | output | 1 | One-cycle pulse when `alarm` toggles |
| err_hold | output | 16 | Error count captured by the last `rd_req` |

## Verification
The alarm filter is driven with runs of exactly ten agreeing frames in both directions. It is also driven with a run of nine that is broken by one agreeing frame and then followed by a full run, which separates a consecutive counter from a cumulative one. A further pattern mixes bare frame strobes and uncommitted bytes into a run, which shows whether commit depends on a captured byte.

The counter is fed every legal nibble value and then every illegal one. This separates adding the value from adding one per frame, and shows whether out-of-range codes are treated as zero. A long stream of value-8 frames drives the counter to its ceiling. Finally, a latch pulse placed in the same cycle as a commit shows whether the increment in that cycle is kept or lost.

// File: rtl/plcp_mon_pkg.sv
package plcp_mon_pkg;

   localparam int STAT_W = 8;   // width of the path status byte
   localparam int REI_W  = 4;   // width of the remote error field (MSBs)

   typedef struct packed {
      logic             flag;   // remote alarm flag
      logic [REI_W-1:0] rei;    // remote error value
   } stat_fields_t;

endpackage

// File: rtl/plcp_stat_capture.sv
module plcp_stat_capture
   import plcp_mon_pkg::*;
#(
   parameter int ALM_POS = 5    // alarm flag position, 1 = MSB
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STAT_W-1:0]   stat_byte,
   input  logic                stat_vld,
   input  logic                frame_sof,
   output logic                commit,
   output stat_fields_t        fields
);

   localparam int FLAG_IDX = STAT_W - ALM_POS;
   localparam logic [STAT_W-1:0] USED_MASK =
      (((STAT_W)'(1) << REI_W) - 1) << (STAT_W - REI_W) | ((STAT_W)'(1) << FLAG_IDX);

   generate
      if (ALM_POS <= REI_W || ALM_POS > STAT_W) begin : g_bad_pos
         $error("ALM_POS must select a bit outside the error field");
      end
   endgenerate

   logic [STAT_W-1:0] byte_q;
   logic              pend_q;
   logic              unused_rest;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q <= '0;
         pend_q <= 1'b0;
      end else begin
         if (stat_vld) begin
            byte_q <= stat_byte;
         end
         if (stat_vld) begin
            pend_q <= 1'b1;
         end else if (frame_sof) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign commit      = frame_sof & pend_q;
   assign fields.flag = byte_q[FLAG_IDX];
   assign fields.rei  = byte_q[STAT_W-1 -: REI_W];
   assign unused_rest = ^(byte_q & ~USED_MASK);

   // R10
   commit_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !stat_vld) |=> !pend_q);

endmodule

// File: rtl/plcp_alarm_filter.sv
module plcp_alarm_filter #(
   parameter int RUN_LEN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   input  logic flag,
   output logic alarm,
   output logic alarm_chg
);

   localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

   generate
      if (RUN_LEN < 2) begin : g_bad_run
         $error("RUN_LEN must be at least 2");
      end
   endgenerate

   logic             alarm_q;
   logic             chg_q;
   logic [RUN_W-1:0] run_q;
   logic             disagree;

   assign disagree = flag ^ alarm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= 1'b0;
         chg_q   <= 1'b0;
         run_q   <= '0;
      end else begin
         chg_q <= 1'b0;
         if (commit) begin
            if (!disagree) begin
               run_q <= '0;
            end else if (run_q == RUN_LAST) begin
               run_q   <= '0;
               alarm_q <= flag;
               chg_q   <= 1'b1;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   end

   assign alarm     = alarm_q;
   assign alarm_chg = chg_q;

   // R5
   toggle_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_q != $past(alarm_q)) |-> chg_q);

   // R5
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_q |=> !chg_q);

   // R4
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_LAST);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(alarm_q) && $stable(run_q)));

endmodule

// File: rtl/plcp_rei_accum.sv
module plcp_rei_accum
   import plcp_mon_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int REI_MAX = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [REI_W-1:0] rei,
   input  logic             rd_req,
   output logic [CNT_W-1:0] err_hold
);

   generate
      if (CNT_W <= REI_W) begin : g_bad_cnt
         $error("CNT_W must exceed the error field width");
      end
      if (REI_MAX >= (1 << REI_W)) begin : g_bad_max
         $error("REI_MAX must be representable in the error field");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hold_q;
   logic [REI_W-1:0] weight;
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] sat_sum;

   always_comb begin
      weight = '0;
      if (commit && (rei <= REI_W'(REI_MAX))) begin
         weight = rei;
      end
   end

   assign sum     = {1'b0, cnt_q} + (CNT_W + 1)'(weight);
   assign sat_sum = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hold_q <= '0;
      end else if (rd_req) begin
         hold_q <= cnt_q;
         cnt_q  <= CNT_W'(weight);
      end else begin
         cnt_q <= sat_sum;
      end
   end

   assign err_hold = hold_q;

   // R8
   sat_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '1 && !rd_req) |=> cnt_q == '1);

   // R9
   latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> hold_q == $past(cnt_q));

   // R6
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (cnt_q >= $past(cnt_q)) && (cnt_q - $past(cnt_q) <= CNT_W'(REI_MAX)));

   // R7
   no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !rd_req) |=> $stable(cnt_q));

endmodule

// File: rtl/plcp_status_mon.sv
module plcp_status_mon
   import plcp_mon_pkg::*;
#(
   parameter int RUN_LEN = 10,
   parameter int CNT_W   = 16,
   parameter int REI_MAX = 8,
   parameter int ALM_POS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       stat_byte,
   input  logic             stat_vld,
   input  logic             frame_sof,
   input  logic             rd_req,
   output logic             alarm,
   output logic             alarm_chg,
   output logic [CNT_W-1:0] err_hold
);

   generate
      if (STAT_W != 8) begin : g_bad_w
         $error("status byte width must be 8");
      end
   endgenerate

   logic         commit;
   stat_fields_t fields;

   plcp_stat_capture #(
      .ALM_POS (ALM_POS)
   ) i_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_byte (stat_byte),
      .stat_vld  (stat_vld),
      .frame_sof (frame_sof),
      .commit    (commit),
      .fields    (fields)
   );

   plcp_alarm_filter #(
      .RUN_LEN (RUN_LEN)
   ) i_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .flag      (fields.flag),
      .alarm     (alarm),
      .alarm_chg (alarm_chg)
   );

   plcp_rei_accum #(
      .CNT_W   (CNT_W),
      .REI_MAX (REI_MAX)
   ) i_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .rei      (fields.rei),
      .rd_req   (rd_req),
      .err_hold (err_hold)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!alarm && !alarm_chg && err_hold == '0));

endmodule

// File: tb/test_plcp_status_mon.sv
module test_plcp_status_mon;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  stat_byte = '0;
   logic        stat_vld = 1'b0;
   logic        frame_sof = 1'b0;
   logic        rd_req = 1'b0;
   logic        alarm;
   logic        alarm_chg;
   logic [15:0] err_hold;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   plcp_status_mon i_plcp_status_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_byte (stat_byte),
      .stat_vld  (stat_vld),
      .frame_sof (frame_sof),
      .rd_req    (rd_req),
      .alarm     (alarm),
      .alarm_chg (alarm_chg),
      .err_hold  (err_hold)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one frame: capture byte, then commit on the next cycle
   task automatic send_frame(input logic [7:0] b);
      @(negedge clk);
      stat_byte = b;
      stat_vld  = 1'b1;
      @(negedge clk);
      stat_vld  = 1'b0;
      frame_sof = 1'b1;
      @(negedge clk);
      frame_sof = 1'b0;
   endtask

   task automatic bare_sof();
      @(negedge clk);
      frame_sof = 1'b1;
      @(negedge clk);
      frame_sof = 1'b0;
   endtask

   task automatic latch();
      @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic t_reset();
      check(alarm == 1'b0, "R1 alarm", alarm, 0);
      check(alarm_chg == 1'b0, "R1 chg", alarm_chg, 0);
      check(err_hold == 16'h0, "R1 hold", err_hold, 0);
      latch();
      check(err_hold == 16'h0, "R1 live count", err_hold, 0);
   endtask

   task automatic t_legal_rei();
      int exp = 0;
      for (int v = 0; v <= 8; v++) begin
         send_frame(8'(v << 4));
         exp += v;
      end
      latch();
      check(err_hold == 16'(exp), "R6 legal sum", err_hold, exp);
      check(alarm == 1'b0, "R6 no alarm", alarm, 0);
   endtask

   task automatic t_illegal_rei();
      for (int v = 9; v <= 15; v++) send_frame(8'(v << 4));
      send_frame(8'h30);
      latch();
      check(err_hold == 16'd3, "R7 illegal zero", err_hold, 3);
   endtask

   task automatic t_commit_gate();
      @(negedge clk);
      stat_byte = 8'h80;
      stat_vld  = 1'b1;
      @(negedge clk);
      stat_vld  = 1'b0;
      latch();
      check(err_hold == 16'd0, "R10 uncommitted byte", err_hold, 0);
      bare_sof();
      bare_sof();
      latch();
      check(err_hold == 16'd8, "R10 single commit", err_hold, 8);
      for (int i = 0; i < 9; i++) send_frame(8'h08);
      for (int i = 0; i < 4; i++) bare_sof();
      check(alarm == 1'b0, "R10 bare strobes no set", alarm, 0);
      send_frame(8'h08);
      check(alarm == 1'b1, "R10 run survives bare strobes", alarm, 1);
      check(alarm_chg == 1'b1, "R5 pulse at set", alarm_chg, 1);
      for (int i = 0; i < 10; i++) send_frame(8'h00);
      check(alarm == 1'b0, "R10 cleanup clear", alarm, 0);
   endtask

   task automatic t_set();
      bit early = 0;
      for (int i = 0; i < 9; i++) begin
         send_frame(8'h08);
         if (alarm || alarm_chg) early = 1;
      end
      check(!early, "R2 no early set", early, 0);
      send_frame(8'h08);
      check(alarm == 1'b1, "R2 set at tenth", alarm, 1);
      check(alarm_chg == 1'b1, "R5 pulse on set", alarm_chg, 1);
      @(negedge clk);
      check(alarm_chg == 1'b0, "R5 pulse one cycle", alarm_chg, 0);
      send_frame(8'h08);
      check(alarm == 1'b1 && !alarm_chg, "R4 agreeing keeps", alarm, 1);
   endtask

   task automatic t_clear();
      bit early = 0;
      for (int i = 0; i < 9; i++) begin
         send_frame(8'h00);
         if (!alarm || alarm_chg) early = 1;
      end
      check(!early, "R3 no early clear", early, 0);
      send_frame(8'h00);
      check(alarm == 1'b0, "R3 clear at tenth", alarm, 0);
      check(alarm_chg == 1'b1, "R5 pulse on clear", alarm_chg, 1);
      @(negedge clk);
      check(alarm_chg == 1'b0, "R5 clear pulse one cycle", alarm_chg, 0);
   endtask

   task automatic t_broken_run();
      bit early = 0;
      for (int i = 0; i < 9; i++) send_frame(8'h08);
      send_frame(8'h00);
      for (int i = 0; i < 9; i++) begin
         send_frame(8'h08);
         if (alarm) early = 1;
      end
      check(!early, "R4 broken run restarts", early, 0);
      send_frame(8'h08);
      check(alarm == 1'b1, "R4 full run sets", alarm, 1);
      for (int i = 0; i < 10; i++) send_frame(8'h00);
      check(alarm == 1'b0, "R4 cleanup clear", alarm, 0);
      latch();
   endtask

   task automatic t_same_cycle_latch();
      send_frame(8'h20);
      @(negedge clk);
      stat_byte = 8'h50;
      stat_vld  = 1'b1;
      @(negedge clk);
      stat_vld  = 1'b0;
      frame_sof = 1'b1;
      rd_req    = 1'b1;
      @(negedge clk);
      frame_sof = 1'b0;
      rd_req    = 1'b0;
      check(err_hold == 16'd2, "R9 hold old count", err_hold, 2);
      latch();
      check(err_hold == 16'd5, "R9 increment kept", err_hold, 5);
      latch();
      check(err_hold == 16'd0, "R9 cleared", err_hold, 0);
   endtask

   task automatic t_saturate();
      for (int i = 0; i < 8200; i++) send_frame(8'h80);
      latch();
      check(err_hold == 16'hFFFF, "R8 saturate", err_hold, 16'hFFFF);
      send_frame(8'h10);
      latch();
      check(err_hold == 16'd1, "R8 restart after read", err_hold, 1);
   endtask

   initial begin
      #1;
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_legal_rei();
            t_illegal_rei();
            t_commit_gate();
            t_set();
            t_clear();
            t_broken_run();
            t_same_cycle_latch();
            t_saturate();
         end
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule